// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block keeps one sticky pending bit per asynchronous interrupt source and picks at most one of them in each cycle in which the core signals that it can accept an interrupt. Timers, the doorbell unit and external pins raise requests through a set vector. Software withdraws a request through a clear vector. The selection follows a fixed priority chain. Some links in that chain are gated by the critical enable, some by the external enable, and one by a dedicated hypervisor-decrementer condition.

When a source is chosen, the block drives a valid strobe and the source's code in the same cycle. On the following clock edge it retires the pending bit, but only for edge-style sources. The two level-style sources, critical external and external, stay pending until software clears them or the pin-side logic stops re-raising them. All other requests stay pending and compete again in the next accepting cycle.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and on release, all pending bits are 0 and `take_valid_o` is 0.
- R2: A 1 on `req_set_i[k]` makes `pending_o[k]` 1 after the next clock edge. A 1 on `req_clr_i[k]` alone makes it 0. When set and clear hit the same bit in the same cycle, set wins.
- R3: Source code 0 (reset request) ranks highest and code 1 (machine check) ranks next. Neither is gated by any enable.
- R4: Source code 2 (hypervisor decrementer) ranks after machine check. It qualifies only when `hdec_en_i` is 1 and at least one of these holds: `ext_en_i` is 1, `hv_mode_i` is 0, or `prob_state_i` is 1.
- R5: Source code 3 (critical external) qualifies only when `crit_en_i` is 1, and ranks after code 2.
- R6: Codes 4 to 12 qualify only when `ext_en_i` is 1. They rank in ascending code order: 4 watchdog, 5 critical doorbell, 6 fixed-interval timer, 7 programmable-interval timer, 8 decrementer, 9 external, 10 doorbell, 11 performance monitor, 12 thermal.
- R7: Level-style sources (codes 3 and 9) stay pending after being taken.
- R8: Any other taken source has its pending bit cleared on the edge after the take, unless a set for that bit arrives in the same cycle.
- R9: At most one source is taken per cycle. Every source that was not taken keeps its pending bit.
- R10: While `accept_i` is 0, `take_valid_o` is 0 and no pending bit changes except through set or clear.
- R11: When no pending source qualifies, `take_valid_o` is 0 and `take_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 13 | Per-source request raise, bit index = source code |
| req_clr_i | input | 13 | Per-source request withdraw, bit index = source code |
| accept_i | input | 1 | Core can accept an interrupt this cycle |
| crit_en_i | input | 1 | Critical interrupt enable from machine state |
| ext_en_i | input | 1 | External interrupt enable from machine state |
| hv_mode_i | input | 1 | Core is in hypervisor mode |
| prob_state_i | input | 1 | Core is in problem (user) state |
| hdec_en_i | input | 1 | Hypervisor decrementer interrupt enable control |
| take_valid_o | output | 1 | A source is taken this cycle |
| take_code_o | output | 4 | Code of the taken source, 0 when not valid |
| pending_o | output | 13 | Current pending bits, bit index = source code |

## Verification
The bench builds the block with its package defaults: 13 sources and a 4-bit code. This makes every gating class and every adjacent pair in the chain reachable with short preload patterns.

A vector table preloads chosen pending masks under chosen enable combinations. It checks the code picked and the pending vector left behind. This covers both sides of the hypervisor-decrementer condition and the cut-off between the critical and external groups.

Directed cases cover the following:
- set against clear on the same bit;
- a re-raise in the same cycle as a take;
- repeated takes of a level source;
- holding the pending state while accept is low.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 13;
  localparam int CODE_W  = $clog2(NUM_SRC);

  // Source index doubles as priority rank (lower wins) and output code
  localparam int SRC_RST    = 0;
  localparam int SRC_MCHK   = 1;
  localparam int SRC_HDEC   = 2;
  localparam int SRC_CEXT   = 3;
  localparam int SRC_WDOG   = 4;
  localparam int SRC_CDBELL = 5;
  localparam int SRC_FIT    = 6;
  localparam int SRC_PIT    = 7;
  localparam int SRC_DEC    = 8;
  localparam int SRC_EXT    = 9;
  localparam int SRC_DBELL  = 10;
  localparam int SRC_PERF   = 11;
  localparam int SRC_THERM  = 12;

  localparam logic [NUM_SRC-1:0] LEVEL_MASK =
    NUM_SRC'((1 << SRC_CEXT) | (1 << SRC_EXT));

  typedef enum logic [1:0] {
    GATE_NONE,
    GATE_HDEC,
    GATE_CRIT,
    GATE_EXT
  } gate_e;

  function automatic gate_e gate_of(int idx);
    if (idx <= SRC_MCHK)      return GATE_NONE;
    else if (idx == SRC_HDEC) return GATE_HDEC;
    else if (idx == SRC_CEXT) return GATE_CRIT;
    else                      return GATE_EXT;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int                 N     = irq_arb_pkg::NUM_SRC,
  parameter logic [N-1:0]       LEVEL = irq_arb_pkg::LEVEL_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    logic retire;

    // level sources ignore the take strobe
    if (LEVEL[i]) begin : g_lvl
      assign retire = clr_i[i];
    end else begin : g_edge
      assign retire = clr_i[i] | take_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (set_i[i])  q <= 1'b1;
      else if (retire)    q <= 1'b0;
    end

    assign pend_o[i] = q;

    // R2
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_o[i]);
    // R2
    clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    // R10
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i] && !take_i[i]) |=> $stable(pend_o[i]));
    if (LEVEL[i]) begin : g_lvl_chk
      // R7
      level_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i[i] && !clr_i[i]) |=> pend_o[i]);
    end
  end

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_arb_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] pend_i,
  input  logic         crit_en_i,
  input  logic         ext_en_i,
  input  logic         hv_mode_i,
  input  logic         prob_state_i,
  input  logic         hdec_en_i,
  output logic [N-1:0] qual_o
);

  logic hdec_ok;
  assign hdec_ok = hdec_en_i & (ext_en_i | ~hv_mode_i | prob_state_i);

  for (genvar i = 0; i < N; i++) begin : g_q
    if (gate_of(i) == GATE_NONE) begin : g_none
      assign qual_o[i] = pend_i[i];
    end else if (gate_of(i) == GATE_HDEC) begin : g_hdec
      assign qual_o[i] = pend_i[i] & hdec_ok;
    end else if (gate_of(i) == GATE_CRIT) begin : g_crit
      assign qual_o[i] = pend_i[i] & crit_en_i;
    end else begin : g_ext
      assign qual_o[i] = pend_i[i] & ext_en_i;
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = irq_arb_pkg::NUM_SRC,
  parameter int CW = irq_arb_pkg::CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  qual_i,
  input  logic          accept_i,
  output logic [N-1:0]  grant_o,
  output logic          valid_o,
  output logic [CW-1:0] code_o
);

  always_comb begin
    grant_o = '0;
    code_o  = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (qual_i[i] && accept_i && !valid_o) begin
        valid_o    = 1'b1;
        grant_o[i] = 1'b1;
        code_o     = CW'(i);
      end
    end
  end

  // R9
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R9
  grant_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> qual_i[code_o]);
  // R11
  none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_i == '0) |-> (!valid_o && code_o == '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_set_i,
  input  logic [N-1:0]  req_clr_i,
  input  logic          accept_i,
  input  logic          crit_en_i,
  input  logic          ext_en_i,
  input  logic          hv_mode_i,
  input  logic          prob_state_i,
  input  logic          hdec_en_i,
  output logic          take_valid_o,
  output logic [CW-1:0] take_code_o,
  output logic [N-1:0]  pending_o
);

  logic [N-1:0] pend;
  logic [N-1:0] qual;
  logic [N-1:0] grant;

  irq_pend_bank #(.N(N), .LEVEL(LEVEL_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_set_i),
    .clr_i  (req_clr_i),
    .take_i (grant),
    .pend_o (pend)
  );

  irq_qualify #(.N(N)) u_qual (
    .pend_i       (pend),
    .crit_en_i    (crit_en_i),
    .ext_en_i     (ext_en_i),
    .hv_mode_i    (hv_mode_i),
    .prob_state_i (prob_state_i),
    .hdec_en_i    (hdec_en_i),
    .qual_o       (qual)
  );

  irq_pick #(.N(N), .CW(CW)) u_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qual_i   (qual),
    .accept_i (accept_i),
    .grant_o  (grant),
    .valid_o  (take_valid_o),
    .code_o   (take_code_o)
  );

  assign pending_o = pend;

  // R3
  rst_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && pending_o[SRC_RST]) |-> (take_valid_o && take_code_o == CW'(SRC_RST)));
  // R3
  mchk_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !pending_o[SRC_RST] && pending_o[SRC_MCHK])
      |-> (take_valid_o && take_code_o == CW'(SRC_MCHK)));
  // R4
  hdec_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_valid_o && take_code_o == CW'(SRC_HDEC))
      |-> (hdec_en_i && (ext_en_i || !hv_mode_i || prob_state_i)));
  // R5
  crit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_valid_o && take_code_o == CW'(SRC_CEXT)) |-> crit_en_i);
  // R6
  ext_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_valid_o && take_code_o >= CW'(SRC_WDOG)) |-> ext_en_i);
  // R8
  edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_valid_o && take_code_o == CW'(SRC_WDOG) && !req_set_i[SRC_WDOG])
      |=> !pending_o[SRC_WDOG]);
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |-> !take_valid_o);

endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  localparam int N  = 13;
  localparam int CW = 4;
  localparam int NV = 19;

  // {mask[12:0], {crit,ext,hv,prob,hden}, exp_valid, exp_code[3:0]}
  localparam logic [22:0] VEC [NV] = '{
    {13'h1FFF, 5'b00000, 1'b1, 4'd0},
    {13'h1002, 5'b00000, 1'b1, 4'd1},
    {13'h0004, 5'b00101, 1'b0, 4'd0},
    {13'h0004, 5'b00001, 1'b1, 4'd2},
    {13'h0004, 5'b00111, 1'b1, 4'd2},
    {13'h0004, 5'b01000, 1'b0, 4'd0},
    {13'h001C, 5'b11101, 1'b1, 4'd2},
    {13'h0018, 5'b11000, 1'b1, 4'd3},
    {13'h0018, 5'b01000, 1'b1, 4'd4},
    {13'h0008, 5'b01000, 1'b0, 4'd0},
    {13'h1FC0, 5'b01000, 1'b1, 4'd6},
    {13'h0180, 5'b01000, 1'b1, 4'd7},
    {13'h0700, 5'b01000, 1'b1, 4'd8},
    {13'h0E00, 5'b01000, 1'b1, 4'd9},
    {13'h1C00, 5'b01000, 1'b1, 4'd10},
    {13'h1800, 5'b01000, 1'b1, 4'd11},
    {13'h1000, 5'b01000, 1'b1, 4'd12},
    {13'h0060, 5'b01000, 1'b1, 4'd5},
    {13'h1000, 5'b10000, 1'b0, 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  set_v = '0;
  logic [N-1:0]  clr_v = '0;
  logic          accept = 1'b0;
  logic          crit_en = 1'b0, ext_en = 1'b0, hv = 1'b0, prob = 1'b0, hden = 1'b0;
  logic          valid;
  logic [CW-1:0] code;
  logic [N-1:0]  pend;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_arbiter uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_set_i    (set_v),
    .req_clr_i    (clr_v),
    .accept_i     (accept),
    .crit_en_i    (crit_en),
    .ext_en_i     (ext_en),
    .hv_mode_i    (hv),
    .prob_state_i (prob),
    .hdec_en_i    (hden),
    .take_valid_o (valid),
    .take_code_o  (code),
    .pending_o    (pend)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string prio_tag(logic v, logic [3:0] c);
    if (!v)          return "R11";
    else if (c <= 1) return "R3";
    else if (c == 2) return "R4";
    else if (c == 3) return "R5";
    else             return "R6";
  endfunction

  task automatic clear_all();
    @(negedge clk); clr_v = '1; set_v = '0; accept = 1'b0;
    @(negedge clk); clr_v = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1
    repeat (2) @(negedge clk);
    chk("R1 pending in reset", 32'(pend), 0);
    chk("R1 valid in reset", 32'(valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 pending after release", 32'(pend), 0);

    for (int v = 0; v < NV; v++) begin
      logic [N-1:0] mask;
      logic [4:0]   en;
      logic         ev;
      logic [3:0]   ec;
      logic [N-1:0] after;
      {mask, en, ev, ec} = VEC[v];
      after = mask;
      if (ev && ec != 4'd3 && ec != 4'd9) after[ec] = 1'b0;
      @(negedge clk); set_v = mask; accept = 1'b0;
      @(negedge clk); set_v = '0; {crit_en, ext_en, hv, prob, hden} = en; accept = 1'b1;
      #1;
      chk(prio_tag(ev, ec), 32'(valid), 32'(ev));
      chk(prio_tag(ev, ec), 32'(code), 32'(ec));
      @(negedge clk); accept = 1'b0;
      // R9 lower-ranked requests survive, taken edge source retired
      chk("R9", 32'(pend), 32'(after));
      clear_all();
    end
    {crit_en, ext_en, hv, prob, hden} = 5'b0;

    // R2 set beats clear
    @(negedge clk); set_v = 13'h0040; clr_v = 13'h0040;
    @(negedge clk); set_v = '0; clr_v = '0;
    chk("R2 set wins", 32'(pend), 32'h40);
    @(negedge clk); clr_v = 13'h0040;
    @(negedge clk); clr_v = '0;
    chk("R2 clear", 32'(pend), 0);

    // R10 accept low
    @(negedge clk); set_v = 13'h0010;
    @(negedge clk); set_v = '0; ext_en = 1'b1; accept = 1'b0;
    #1 chk("R10 no take", 32'(valid), 0);
    @(negedge clk);
    #1 chk("R10 no take 2", 32'(valid), 0);
    chk("R10 pending kept", 32'(pend), 32'h10);

    // R8 re-raise during take keeps bit, next take clears
    @(negedge clk); accept = 1'b1; set_v = 13'h0010;
    #1 chk("R8 take code", 32'(code), 4);
    @(negedge clk); accept = 1'b0; set_v = '0;
    chk("R8 re-raise kept", 32'(pend), 32'h10);
    @(negedge clk); accept = 1'b1;
    #1 chk("R8 take valid", 32'(valid), 1);
    @(negedge clk); accept = 1'b0;
    chk("R8 retired", 32'(pend), 0);

    // R7 level source repeatedly taken
    @(negedge clk); set_v = 13'h0200;
    @(negedge clk); set_v = '0; accept = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R7 level take", 32'(code), 9);
      @(negedge clk);
    end
    chk("R7 level kept", 32'(pend), 32'h200);
    accept = 1'b0; clr_v = 13'h0200;
    @(negedge clk); clr_v = '0;
    chk("R7 cleared by software", 32'(pend), 0);

    // R11 nothing pending, all enables on
    crit_en = 1'b1; ext_en = 1'b1; hden = 1'b1; accept = 1'b1;
    #1 chk("R11 valid", 32'(valid), 0);
    chk("R11 code", 32'(code), 0);
    @(negedge clk); accept = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule